// File: doc/BRIEF.md
# Circuit/Packet Flit Classifier with Retagging

This block sits at the input side of one data port of a hybrid router that carries both circuit-switched and packet-switched traffic. Each arriving flit has a one-bit circuit marker and a circuit number. If the marker is set and the circuit is intact at this router, the flit bypasses buffering and arbitration. It leaves one cycle later on the switch-traversal side, carrying the output port that was recorded when that circuit was set up. If the marker is clear, the flit goes into a small packet FIFO, which the packet pipeline drains.

A local circuit table can reconfigure (tear) a circuit at this router. From the cycle after the tear pulse, circuit-marked flits for that circuit number are retagged: their marker is cleared and they enter the packet FIFO. They leave the FIFO flagged as retagged, so they stay packet flits at every later hop. Retagging for a circuit number stops once a new setup for that number completes locally. A buffer-bound flit that finds the FIFO full, with no dequeue in the same cycle, is dropped and raises a one-cycle overflow flag.

Top module: `cs_flit_sorter`

## Requirements
- R1: After reset, byp_valid, pkt_valid and ovf are low, no circuit is torn, and every circuit's stored output port is 0.
- R2: A valid flit with in_circ=1 whose circuit is not torn appears one cycle later on byp_valid/byp_data/byp_cid, with byp_port equal to the port of the last completed setup for that circuit. It is not written into the packet FIFO.
- R3: A valid flit with in_circ=0 never produces byp_valid. It is written into the packet FIFO, which returns flits in arrival order with pkt_tag=0.
- R4: When reconf_pulse is high in cycle t for circuit number c, circuit flits for c arriving in cycle t+1 or later go into the packet FIFO. A circuit flit for c arriving in cycle t itself still bypasses.
- R5: Tearing one circuit number does not change the routing of flits on any other circuit number.
- R6: When setup_done is high in cycle t for circuit c, circuit flits for c arriving from cycle t+1 bypass again, using setup_port from cycle t as byp_port.
- R7: A retagged flit leaves the FIFO with pkt_tag=1 and keeps its data and circuit number.
- R8: A buffer-bound flit that arrives while the FIFO holds BUF_DEPTH entries, with no dequeue that cycle, is dropped. ovf is high for exactly the following cycle, and the FIFO contents stay unchanged.
- R9: A buffer-bound flit that arrives while the FIFO is full, in a cycle where pkt_ready pops the head, is accepted without raising ovf.
- R10: When reconf_pulse and setup_done name the same circuit in the same cycle, the circuit ends up torn.
- R11: A cycle with in_valid low produces no bypass output and writes nothing into the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit present |
| in_circ | input | 1 | Circuit marker of the incoming flit |
| in_cid | input | CID_W | Circuit number of the incoming flit |
| in_data | input | DATA_W | Flit payload |
| reconf_pulse | input | 1 | Circuit torn at this router |
| reconf_cid | input | CID_W | Circuit number being torn |
| setup_done | input | 1 | Local setup of a circuit completed |
| setup_cid | input | CID_W | Circuit number being set up |
| setup_port | input | PORT_W | Output port chosen for that circuit |
| byp_valid | output | 1 | Bypass flit to switch traversal |
| byp_cid | output | CID_W | Circuit number of bypass flit |
| byp_port | output | PORT_W | Preconfigured output port |
| byp_data | output | DATA_W | Bypass payload |
| pkt_valid | output | 1 | Packet FIFO not empty |
| pkt_ready | input | 1 | Packet pipeline takes the head |
| pkt_cid | output | CID_W | Circuit number of head flit |
| pkt_tag | output | 1 | Head flit was retagged from a circuit |
| pkt_data | output | DATA_W | Head payload |
| ovf | output | 1 | A buffer-bound flit was dropped last cycle |

## Verification
Circuit flits are swept over every circuit number, first with no circuit torn, then with one torn, then after its setup again. This separates per-circuit tagging from a global switch and shows that the stored port follows each setup. Packet flits on every circuit number check FIFO order and show that the marker alone picks the path. The same-cycle cases (a flit in the tear cycle, tear and setup together, and a full FIFO with or without a pop) pin down which cycle each event takes effect in and where a flit is dropped.

// File: rtl/cs_flit_sorter.sv
`timescale 1ns/1ps
module cs_flit_sorter #(
  parameter int DATA_W    = 16,
  parameter int NUM_CIRC  = 4,
  parameter int PORT_W    = 3,
  parameter int BUF_DEPTH = 4,
  localparam int CID_W = (NUM_CIRC > 1) ? $clog2(NUM_CIRC) : 1,
  localparam int PTR_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
  localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_circ,
  input  logic [CID_W-1:0]  in_cid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              reconf_pulse,
  input  logic [CID_W-1:0]  reconf_cid,
  input  logic              setup_done,
  input  logic [CID_W-1:0]  setup_cid,
  input  logic [PORT_W-1:0] setup_port,
  output logic              byp_valid,
  output logic [CID_W-1:0]  byp_cid,
  output logic [PORT_W-1:0] byp_port,
  output logic [DATA_W-1:0] byp_data,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [CID_W-1:0]  pkt_cid,
  output logic              pkt_tag,
  output logic [DATA_W-1:0] pkt_data,
  output logic              ovf
);
  localparam int ENT_W = DATA_W + CID_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BUF_DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(BUF_DEPTH - 1);

  logic [NUM_CIRC-1:0] torn_q;
  logic [PORT_W-1:0]   port_q [NUM_CIRC];
  logic [ENT_W-1:0]    fifo_q [BUF_DEPTH];
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0]    cnt_q;

  wire hit_torn = torn_q[in_cid];
  wire go_byp   = in_valid && in_circ && !hit_torn;
  wire go_buf   = in_valid && !go_byp;
  wire retag    = in_circ && hit_torn;
  wire pop      = pkt_valid && pkt_ready;
  wire full     = (cnt_q == FULL_CNT);
  wire push     = go_buf && (!full || pop);
  wire drop     = go_buf && full && !pop;

  genvar i;
  generate
    for (i = 0; i < NUM_CIRC; i++) begin : g_circ
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          torn_q[i] <= 1'b0;
          port_q[i] <= '0;
        end else begin
          if (reconf_pulse && reconf_cid == CID_W'(i))
            torn_q[i] <= 1'b1;
          else if (setup_done && setup_cid == CID_W'(i))
            torn_q[i] <= 1'b0;
          if (setup_done && setup_cid == CID_W'(i))
            port_q[i] <= setup_port;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp_valid <= 1'b0;
      byp_cid   <= '0;
      byp_port  <= '0;
      byp_data  <= '0;
      ovf       <= 1'b0;
    end else begin
      byp_valid <= go_byp;
      ovf       <= drop;
      if (go_byp) begin
        byp_cid  <= in_cid;
        byp_port <= port_q[in_cid];
        byp_data <= in_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo_q[wr_ptr] <= {retag, in_cid, in_data};
  end

  assign pkt_valid = (cnt_q != '0);
  assign {pkt_tag, pkt_cid, pkt_data} = fifo_q[rd_ptr];
endmodule

// File: rtl/cs_flit_sorter_chk.sv
`timescale 1ns/1ps
module cs_flit_sorter_chk #(
  parameter int DATA_W    = 16,
  parameter int NUM_CIRC  = 4,
  parameter int BUF_DEPTH = 4,
  localparam int CID_W = (NUM_CIRC > 1) ? $clog2(NUM_CIRC) : 1,
  localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_circ,
  input logic [CID_W-1:0]  in_cid,
  input logic [DATA_W-1:0] in_data,
  input logic              reconf_pulse,
  input logic [CID_W-1:0]  reconf_cid,
  input logic              setup_done,
  input logic [CID_W-1:0]  setup_cid,
  input logic              byp_valid,
  input logic [CID_W-1:0]  byp_cid,
  input logic [DATA_W-1:0] byp_data,
  input logic              ovf,
  input logic [NUM_CIRC-1:0] torn_q,
  input logic [CNT_W-1:0]  cnt_q
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BUF_DEPTH);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !byp_valid);

  a_r3_pkt_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_circ) |=> !byp_valid);

  a_r2_bypass_payload: assert property (@(posedge clk) disable iff (!rst_n)
    byp_valid |-> ($past(in_valid) && $past(in_circ) &&
                   byp_data == $past(in_data) && byp_cid == $past(in_cid)));

  a_r4_torn_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_circ && torn_q[in_cid]) |=> !byp_valid);

  a_r10_reconf_tears: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_pulse |=> torn_q[$past(reconf_cid)]);

  a_r6_setup_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_done && !(reconf_pulse && reconf_cid == setup_cid)) |=> !torn_q[$past(setup_cid)]);

  a_r8_ovf_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(cnt_q) == FULL_CNT);

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
endmodule

bind cs_flit_sorter cs_flit_sorter_chk #(
  .DATA_W(DATA_W), .NUM_CIRC(NUM_CIRC), .BUF_DEPTH(BUF_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_circ(in_circ),
  .in_cid(in_cid), .in_data(in_data), .reconf_pulse(reconf_pulse),
  .reconf_cid(reconf_cid), .setup_done(setup_done), .setup_cid(setup_cid),
  .byp_valid(byp_valid), .byp_cid(byp_cid), .byp_data(byp_data), .ovf(ovf),
  .torn_q(torn_q), .cnt_q(cnt_q)
);

// File: tb/cs_flit_sorter_bench.sv
`timescale 1ns/1ps
module cs_flit_sorter_bench;
  localparam int DW = 16;
  localparam int NC = 4;
  localparam int PW = 3;
  localparam int BD = 4;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_circ = 1'b0;
  logic [CW-1:0] in_cid = '0;
  logic [DW-1:0] in_data = '0;
  logic reconf_pulse = 1'b0, setup_done = 1'b0, pkt_ready = 1'b0;
  logic [CW-1:0] reconf_cid = '0, setup_cid = '0;
  logic [PW-1:0] setup_port = '0;
  logic byp_valid, pkt_valid, pkt_tag, ovf;
  logic [CW-1:0] byp_cid, pkt_cid;
  logic [PW-1:0] byp_port;
  logic [DW-1:0] byp_data, pkt_data;

  int checks = 0;
  int errors = 0;
  bit torn_m [NC];
  int port_m [NC];
  int qd[$];
  int qc[$];
  int qt[$];

  always #2.5 clk = ~clk;

  cs_flit_sorter #(.DATA_W(DW), .NUM_CIRC(NC), .PORT_W(PW), .BUF_DEPTH(BD)) u_cs_flit_sorter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_circ(in_circ), .in_cid(in_cid),
    .in_data(in_data), .reconf_pulse(reconf_pulse), .reconf_cid(reconf_cid),
    .setup_done(setup_done), .setup_cid(setup_cid), .setup_port(setup_port),
    .byp_valid(byp_valid), .byp_cid(byp_cid), .byp_port(byp_port), .byp_data(byp_data),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_cid(pkt_cid), .pkt_tag(pkt_tag),
    .pkt_data(pkt_data), .ovf(ovf));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    in_valid = 0; in_circ = 0; reconf_pulse = 0; setup_done = 0; pkt_ready = 0;
  endtask

  task automatic send(bit c, int id, int d, string req);
    bit to_byp;
    bit exp_ovf;
    to_byp = c && !torn_m[id];
    exp_ovf = !to_byp && (qd.size() == BD);
    in_valid = 1; in_circ = c; in_cid = CW'(id); in_data = DW'(d);
    @(negedge clk);
    quiet();
    chk(req, "byp_valid", int'(byp_valid), int'(to_byp));
    if (to_byp) begin
      chk(req, "byp_data", int'(byp_data), d);
      chk(req, "byp_cid", int'(byp_cid), id);
      chk(req, "byp_port", int'(byp_port), port_m[id]);
    end else if (!exp_ovf) begin
      qd.push_back(d); qc.push_back(id); qt.push_back(int'(c));
    end
    chk(req, "ovf", int'(ovf), int'(exp_ovf));
  endtask

  task automatic setup(int id, int p);
    setup_done = 1; setup_cid = CW'(id); setup_port = PW'(p);
    @(negedge clk);
    quiet();
    torn_m[id] = 0; port_m[id] = p;
  endtask

  task automatic tear(int id);
    reconf_pulse = 1; reconf_cid = CW'(id);
    @(negedge clk);
    quiet();
    torn_m[id] = 1;
  endtask

  task automatic drain(string req);
    while (qd.size() > 0) begin
      chk(req, "pkt_valid", int'(pkt_valid), 1);
      chk(req, "pkt_data", int'(pkt_data), qd[0]);
      chk(req, "pkt_cid", int'(pkt_cid), qc[0]);
      chk(req, "pkt_tag", int'(pkt_tag), qt[0]);
      pkt_ready = 1;
      @(negedge clk);
      pkt_ready = 0;
      void'(qd.pop_front()); void'(qc.pop_front()); void'(qt.pop_front());
    end
    chk(req, "pkt_valid empty", int'(pkt_valid), 0);
  endtask

  task automatic sweep_circ(int base, string req);
    for (int id = 0; id < NC; id++) send(1'b1, id, base + id, req);
  endtask

  initial begin
    for (int k = 0; k < NC; k++) begin torn_m[k] = 0; port_m[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "byp_valid", int'(byp_valid), 0);
    chk("R1", "pkt_valid", int'(pkt_valid), 0);
    chk("R1", "ovf", int'(ovf), 0);
    sweep_circ(16'h1000, "R1");

    for (int id = 0; id < NC; id++) setup(id, id + 2);
    sweep_circ(16'h2000, "R2");
    chk("R2", "pkt_valid", int'(pkt_valid), 0);

    for (int id = 0; id < NC; id++) send(1'b0, id, 16'h3000 + id, "R3");
    drain("R3");

    @(negedge clk);
    chk("R11", "byp_valid idle", int'(byp_valid), 0);
    chk("R11", "pkt_valid idle", int'(pkt_valid), 0);

    reconf_pulse = 1; reconf_cid = 2'd2;
    in_valid = 1; in_circ = 1; in_cid = 2'd2; in_data = 16'h4444;
    @(negedge clk);
    quiet();
    torn_m[2] = 1;
    chk("R4", "tear-cycle flit bypasses", int'(byp_valid), 1);
    chk("R4", "tear-cycle data", int'(byp_data), 16'h4444);

    sweep_circ(16'h5000, "R5");
    send(1'b1, 2, 16'h5555, "R4");
    drain("R7");

    setup(2, 5);
    sweep_circ(16'h6000, "R6");
    chk("R6", "pkt_valid", int'(pkt_valid), 0);

    for (int t = 0; t < NC; t++) begin
      tear(t);
      sweep_circ(16'h7000 + t * 16, "R5");
      drain("R7");
      setup(t, (t + 3) % 8);
    end

    for (int k = 0; k < BD; k++) send(1'b0, k % NC, 16'h8000 + k, "R3");
    send(1'b0, 1, 16'h8888, "R8");
    @(negedge clk);
    chk("R8", "ovf one cycle", int'(ovf), 0);
    drain("R8");

    tear(0);
    for (int k = 0; k < BD; k++) send(1'b0, 3, 16'h9000 + k, "R3");
    send(1'b1, 0, 16'h9999, "R8");
    chk("R9", "head before pop", int'(pkt_data), qd[0]);
    in_valid = 1; in_circ = 1; in_cid = 2'd0; in_data = 16'h9A9A; pkt_ready = 1;
    @(negedge clk);
    quiet();
    void'(qd.pop_front()); void'(qc.pop_front()); void'(qt.pop_front());
    qd.push_back(16'h9A9A); qc.push_back(0); qt.push_back(1);
    chk("R9", "no ovf with pop", int'(ovf), 0);
    drain("R9");

    reconf_pulse = 1; reconf_cid = 2'd1; setup_done = 1; setup_cid = 2'd1; setup_port = 3'd6;
    @(negedge clk);
    quiet();
    torn_m[1] = 1; port_m[1] = 6;
    send(1'b1, 1, 16'hB111, "R10");
    drain("R10");
    setup(1, 6);
    send(1'b1, 1, 16'hB222, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule